// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Controller

This block is the interlock logic of a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). It reads the register indices and a few control bits held in the four pipeline registers between the stages. It also takes the taken/not-taken outcome of the branch comparison done in execute. From these it chooses the source of each execute-stage ALU operand, freezes the front end for one cycle when a load result is needed too early, and kills younger instructions when control flow changes.

Branches are resolved in execute, so a taken branch discards the two instructions behind it. Jumps are resolved in decode, so only the single instruction fetched behind them is discarded. The block remembers each load-use bubble for two cycles. When the bubble reaches the execute/memory register, that register is treated as empty for forwarding, whatever stale fields it still presents. The surrounding datapath owns the register file, the ALU and the memories, and acts on the selects, enables and clears produced here.

Top module: `pipe_hazard_ctl`

## Requirements
- R1: When the instruction in execute is a load (`idex_mem_read`=1) whose nonzero destination `idex_wr` equals a live source of the instruction in decode, the block stalls. In that cycle `pc_we`=0, `ifid_we`=0, `idex_clr`=1 and `ifid_clr`=0. The decode instruction's rs is live unless `ifid_shift`=1, and its rt is live when `ifid_rt_used`=1.
- R2: When `exmem_reg_we`=1 and the nonzero `exmem_wr` equals a live execute source, that operand's select is 2'b10. Operand A uses `idex_rs` and operand B uses `idex_rt`.
- R3: When `memwb_reg_we`=1 and the nonzero `memwb_wr` equals a live execute source, with no memory-stage match, the select is 2'b01. With no match at all, the select is 2'b00, meaning the register file.
- R4: When both forwarding sources match the same operand, the select is 2'b10. Each operand is resolved independently, and the value 2'b11 never appears.
- R5: A stage whose write enable is 0 never forwards. A destination of register 0 never forwards and never causes a stall.
- R6: A taken branch (`ex_br_taken`=1) drives `ifid_clr`=1 and `idex_clr`=1 with `pc_we`=1 and `ifid_we`=1.
- R7: A jump in decode (`ifid_jump`=1) with no stall or branch drives `ifid_clr`=1 and `idex_clr`=0, and leaves `pc_we`=1.
- R8: A shift in decode (`ifid_shift`=1) or in execute (`idex_shift`=1) has its rs ignored for stall and forwarding. An rt whose used flag is 0 is likewise ignored.
- R9: A taken branch overrides a load-use stall in the same cycle, so the flush outputs of R6 appear and no stall occurs. A load-use stall overrides a jump, so `ifid_clr` stays 0 while stalled.
- R10: Two cycles after a stall, the memory-stage path cannot forward (select never 2'b10), while the writeback-stage path still can. In the following cycle the memory-stage path works again. A load-use request suppressed by a taken branch leaves no such blocking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the bubble tracker |
| ifid_rs | input | RW | rs index of the decode-stage instruction |
| ifid_rt | input | RW | rt index of the decode-stage instruction |
| ifid_rt_used | input | 1 | Decode-stage rt is read as a source |
| ifid_shift | input | 1 | Decode-stage instruction is a shift (rs not read) |
| ifid_jump | input | 1 | Decode-stage instruction is an unconditional jump |
| idex_rs | input | RW | rs index of the execute-stage instruction |
| idex_rt | input | RW | rt index of the execute-stage instruction |
| idex_rt_used | input | 1 | Execute-stage rt is an ALU source |
| idex_shift | input | 1 | Execute-stage instruction is a shift (rs not read) |
| idex_mem_read | input | 1 | Execute-stage instruction is a load |
| idex_wr | input | RW | Destination index of the execute-stage instruction |
| ex_br_taken | input | 1 | Branch in execute resolved as taken |
| exmem_reg_we | input | 1 | Memory-stage instruction writes a register |
| exmem_wr | input | RW | Memory-stage destination index |
| memwb_reg_we | input | 1 | Writeback-stage instruction writes a register |
| memwb_wr | input | RW | Writeback-stage destination index |
| fwd_a | output | 2 | Operand A source: 00 regfile, 01 writeback, 10 memory stage |
| fwd_b | output | 2 | Operand B source, same encoding |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Decode register write enable |
| ifid_clr | output | 1 | Turn the decode register into a bubble |
| idex_clr | output | 1 | Turn the execute register into a bubble |

## Verification
The forwarding selects are tried with a match on operand A only, on operand B only, on both sources for one operand, and on one source per operand. These patterns separate a swapped priority from a crossed operand. Matches are repeated with a cleared write enable, a zero destination, a shift or an unused rt, which shows whether each qualifier is honoured. Stalls are triggered through rs and through rt and then combined with a taken branch and with a jump, which fixes the priority order. A timed sequence then follows a stall into its bubble and checks that stale memory-stage fields are blocked for exactly one cycle.

// File: rtl/pipe_hazard_ctl.sv
module pipe_hazard_ctl #(
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] ifid_rs,
  input  logic [RW-1:0] ifid_rt,
  input  logic          ifid_rt_used,
  input  logic          ifid_shift,
  input  logic          ifid_jump,
  input  logic [RW-1:0] idex_rs,
  input  logic [RW-1:0] idex_rt,
  input  logic          idex_rt_used,
  input  logic          idex_shift,
  input  logic          idex_mem_read,
  input  logic [RW-1:0] idex_wr,
  input  logic          ex_br_taken,
  input  logic          exmem_reg_we,
  input  logic [RW-1:0] exmem_wr,
  input  logic          memwb_reg_we,
  input  logic [RW-1:0] memwb_wr,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b,
  output logic          pc_we,
  output logic          ifid_we,
  output logic          ifid_clr,
  output logic          idex_clr
);
  localparam logic [RW-1:0] ZERO_REG = '0;
  localparam logic [1:0] SEL_RF = 2'b00;
  localparam logic [1:0] SEL_WB = 2'b01;
  localparam logic [1:0] SEL_EX = 2'b10;

  logic bub_ex_q, bub_mem_q;
  logic load_use, stall;
  logic mem_ok, wb_ok, a_live, b_live;

  assign load_use = idex_mem_read && (idex_wr != ZERO_REG) &&
                    ((!ifid_shift && ifid_rs == idex_wr) ||
                     (ifid_rt_used && ifid_rt == idex_wr));
  assign stall = load_use && !ex_br_taken;

  assign pc_we    = !stall;
  assign ifid_we  = !stall;
  assign idex_clr = ex_br_taken || stall;
  assign ifid_clr = ex_br_taken || (ifid_jump && !stall);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bub_ex_q  <= 1'b0;
      bub_mem_q <= 1'b0;
    end else begin
      bub_ex_q  <= stall;
      bub_mem_q <= bub_ex_q;
    end
  end

  assign mem_ok = exmem_reg_we && (exmem_wr != ZERO_REG) && !bub_mem_q;
  assign wb_ok  = memwb_reg_we && (memwb_wr != ZERO_REG);
  assign a_live = !idex_shift && (idex_rs != ZERO_REG);
  assign b_live = idex_rt_used && (idex_rt != ZERO_REG);

  assign fwd_a = (a_live && mem_ok && exmem_wr == idex_rs) ? SEL_EX :
                 (a_live && wb_ok  && memwb_wr == idex_rs) ? SEL_WB : SEL_RF;
  assign fwd_b = (b_live && mem_ok && exmem_wr == idex_rt) ? SEL_EX :
                 (b_live && wb_ok  && memwb_wr == idex_rt) ? SEL_WB : SEL_RF;

  assert_stall_freeze_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_we |-> (!ifid_we && idex_clr && !ifid_clr));

  assert_sel_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a != 2'b11) && (fwd_b != 2'b11));

  assert_zero_reg_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (idex_rs == ZERO_REG) |-> (fwd_a == SEL_RF));

  assert_branch_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ex_br_taken |-> (ifid_clr && idex_clr && pc_we && ifid_we));

  assert_jump_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ifid_jump && pc_we && !ex_br_taken) |-> (ifid_clr && !idex_clr));

  assert_no_mem_fwd_over_bubble_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!pc_we, 2) |-> (fwd_a != SEL_EX && fwd_b != SEL_EX));
endmodule

// File: tb/tb_pipe_hazard_ctl.sv
`timescale 1ns/1ps
module tb_pipe_hazard_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [4:0] ifid_rs, ifid_rt, idex_rs, idex_rt, idex_wr, exmem_wr, memwb_wr;
  logic ifid_rt_used, ifid_shift, ifid_jump, idex_rt_used, idex_shift, idex_mem_read;
  logic ex_br_taken, exmem_reg_we, memwb_reg_we;
  logic [1:0] fwd_a, fwd_b;
  logic pc_we, ifid_we, ifid_clr, idex_clr;

  pipe_hazard_ctl #(.RW(5)) dut (
    .clk(clk), .rst_n(rst_n),
    .ifid_rs(ifid_rs), .ifid_rt(ifid_rt), .ifid_rt_used(ifid_rt_used),
    .ifid_shift(ifid_shift), .ifid_jump(ifid_jump),
    .idex_rs(idex_rs), .idex_rt(idex_rt), .idex_rt_used(idex_rt_used),
    .idex_shift(idex_shift), .idex_mem_read(idex_mem_read), .idex_wr(idex_wr),
    .ex_br_taken(ex_br_taken),
    .exmem_reg_we(exmem_reg_we), .exmem_wr(exmem_wr),
    .memwb_reg_we(memwb_reg_we), .memwb_wr(memwb_wr),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .pc_we(pc_we), .ifid_we(ifid_we),
    .ifid_clr(ifid_clr), .idex_clr(idex_clr)
  );

  typedef struct packed {
    logic [4:0] i_rs; logic [4:0] i_rt; logic i_rtu; logic i_sh; logic i_j;
    logic [4:0] x_rs; logic [4:0] x_rt; logic x_rtu; logic x_sh; logic x_mr; logic [4:0] x_wr;
    logic br; logic em_we; logic [4:0] em_wr; logic mw_we; logic [4:0] mw_wr;
    logic [7:0] exp; logic [3:0] req;
  } vec_t;

  // exp = {fwd_a, fwd_b, pc_we, ifid_we, ifid_clr, idex_clr}
  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{5'd0,5'd0,1'b0,1'b0,1'b0, 5'd0,5'd0,1'b0,1'b0,1'b0,5'd0, 1'b0, 1'b0,5'd0, 1'b0,5'd0, 8'b00_00_1100, 4'd3}, // R3 idle
    '{5'd0,5'd0,1'b0,1'b0,1'b0, 5'd3,5'd4,1'b1,1'b0,1'b0,5'd0, 1'b0, 1'b1,5'd3, 1'b0,5'd0, 8'b10_00_1100, 4'd2}, // R2 A
    '{5'd0,5'd0,1'b0,1'b0,1'b0, 5'd3,5'd4,1'b1,1'b0,1'b0,5'd0, 1'b0, 1'b1,5'd4, 1'b0,5'd0, 8'b00_10_1100, 4'd2}, // R2 B
    '{5'd0,5'd0,1'b0,1'b0,1'b0, 5'd3,5'd4,1'b1,1'b0,1'b0,5'd0, 1'b0, 1'b0,5'd0, 1'b1,5'd3, 8'b01_00_1100, 4'd3}, // R3 A
    '{5'd0,5'd0,1'b0,1'b0,1'b0, 5'd3,5'd4,1'b1,1'b0,1'b0,5'd0, 1'b0, 1'b1,5'd3, 1'b1,5'd3, 8'b10_00_1100, 4'd4}, // R4 both on A
    '{5'd0,5'd0,1'b0,1'b0,1'b0, 5'd3,5'd4,1'b1,1'b0,1'b0,5'd0, 1'b0, 1'b1,5'd3, 1'b1,5'd4, 8'b10_01_1100, 4'd4}, // R4 split
    '{5'd0,5'd0,1'b0,1'b0,1'b0, 5'd3,5'd4,1'b1,1'b0,1'b0,5'd0, 1'b0, 1'b0,5'd3, 1'b0,5'd4, 8'b00_00_1100, 4'd5}, // R5 no we
    '{5'd0,5'd0,1'b0,1'b0,1'b0, 5'd0,5'd0,1'b1,1'b0,1'b0,5'd0, 1'b0, 1'b1,5'd0, 1'b1,5'd0, 8'b00_00_1100, 4'd5}, // R5 reg0
    '{5'd7,5'd0,1'b0,1'b0,1'b0, 5'd1,5'd7,1'b0,1'b0,1'b1,5'd7, 1'b0, 1'b0,5'd0, 1'b0,5'd0, 8'b00_00_0001, 4'd1}, // R1 via rs
    '{5'd2,5'd7,1'b1,1'b0,1'b0, 5'd1,5'd7,1'b0,1'b0,1'b1,5'd7, 1'b0, 1'b0,5'd0, 1'b0,5'd0, 8'b00_00_0001, 4'd1}, // R1 via rt
    '{5'd2,5'd7,1'b0,1'b0,1'b0, 5'd1,5'd7,1'b0,1'b0,1'b1,5'd7, 1'b0, 1'b0,5'd0, 1'b0,5'd0, 8'b00_00_1100, 4'd8}, // R8 rt unused
    '{5'd7,5'd0,1'b0,1'b1,1'b0, 5'd1,5'd7,1'b0,1'b0,1'b1,5'd7, 1'b0, 1'b0,5'd0, 1'b0,5'd0, 8'b00_00_1100, 4'd8}, // R8 shift in ID
    '{5'd0,5'd0,1'b0,1'b0,1'b0, 5'd3,5'd4,1'b1,1'b1,1'b0,5'd0, 1'b0, 1'b1,5'd3, 1'b0,5'd0, 8'b00_00_1100, 4'd8}, // R8 shift in EX
    '{5'd0,5'd0,1'b0,1'b0,1'b0, 5'd3,5'd4,1'b0,1'b0,1'b0,5'd0, 1'b0, 1'b1,5'd4, 1'b1,5'd4, 8'b00_00_1100, 4'd8}, // R8 rt unused EX
    '{5'd0,5'd0,1'b0,1'b0,1'b0, 5'd1,5'd0,1'b0,1'b0,1'b1,5'd0, 1'b0, 1'b0,5'd0, 1'b0,5'd0, 8'b00_00_1100, 4'd5}, // R5 load to reg0
    '{5'd0,5'd0,1'b0,1'b0,1'b0, 5'd0,5'd0,1'b0,1'b0,1'b0,5'd0, 1'b1, 1'b0,5'd0, 1'b0,5'd0, 8'b00_00_1111, 4'd6}, // R6 branch
    '{5'd0,5'd0,1'b0,1'b0,1'b1, 5'd0,5'd0,1'b0,1'b0,1'b0,5'd0, 1'b0, 1'b0,5'd0, 1'b0,5'd0, 8'b00_00_1110, 4'd7}, // R7 jump
    '{5'd7,5'd0,1'b0,1'b0,1'b0, 5'd1,5'd7,1'b0,1'b0,1'b1,5'd7, 1'b1, 1'b0,5'd0, 1'b0,5'd0, 8'b00_00_1111, 4'd9}, // R9 branch beats stall
    '{5'd7,5'd0,1'b0,1'b0,1'b1, 5'd1,5'd7,1'b0,1'b0,1'b1,5'd7, 1'b0, 1'b0,5'd0, 1'b0,5'd0, 8'b00_00_0001, 4'd9}  // R9 stall beats jump
  };

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  task automatic drive(input vec_t v);
    ifid_rs = v.i_rs; ifid_rt = v.i_rt; ifid_rt_used = v.i_rtu; ifid_shift = v.i_sh; ifid_jump = v.i_j;
    idex_rs = v.x_rs; idex_rt = v.x_rt; idex_rt_used = v.x_rtu; idex_shift = v.x_sh;
    idex_mem_read = v.x_mr; idex_wr = v.x_wr; ex_br_taken = v.br;
    exmem_reg_we = v.em_we; exmem_wr = v.em_wr; memwb_reg_we = v.mw_we; memwb_wr = v.mw_wr;
  endtask

  task automatic check(input logic [7:0] exp, input int req, input string what);
    logic [7:0] got;
    got = {fwd_a, fwd_b, pc_we, ifid_we, ifid_clr, idex_clr};
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL R%0d %s: got %b expected %b", req, what, got, exp);
    end
  endtask

  vec_t idle;
  vec_t v;

  initial begin
    idle = VECS[0];
    drive(idle);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(8'b00_00_1100, 3, "reset state"); // R3 default selects
    @(posedge clk); #1 rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(posedge clk); #1 drive(VECS[i]);
      @(negedge clk); check(VECS[i].exp, int'(VECS[i].req), $sformatf("vector %0d", i));
      @(posedge clk); #1 drive(idle);
      @(posedge clk); #1;
      @(posedge clk); #1;
    end

    // R10: stall, bubble cycle, then stale memory-stage fields must not forward
    @(posedge clk); #1 drive(VECS[8]);
    @(negedge clk); check(8'b00_00_0001, 10, "stall cycle");
    @(posedge clk); #1 drive(idle);
    @(posedge clk); #1;
    v = idle; v.x_rs = 5'd7; v.x_rt = 5'd9; v.x_rtu = 1'b1;
    v.em_we = 1'b1; v.em_wr = 5'd9; v.mw_we = 1'b1; v.mw_wr = 5'd7;
    drive(v);
    @(negedge clk); check(8'b01_00_1100, 10, "bubble in memory stage");
    @(posedge clk); #1;
    @(negedge clk); check(8'b01_10_1100, 10, "memory path restored");

    // R10: stall suppressed by a branch leaves no blocking
    @(posedge clk); #1 drive(VECS[17]);
    @(posedge clk); #1 drive(idle);
    @(posedge clk); #1 drive(v);
    @(negedge clk); check(8'b01_10_1100, 10, "no bubble after flush");

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule